// File: doc/BRIEF.md
# Second-Operand Immediate Generator

This block forms the second source operand of a 32-bit fixed-width RISC instruction. It receives the raw instruction word and a 4-bit operand-select code from an upstream opcode table. From these it produces exactly one of three things: a register-read request, a 64-bit immediate, or a special-register read request. Each of these carries its own valid flag.

Immediates are taken from fixed instruction fields. Each is then shifted, zero-extended or sign-extended according to the select code. Instruction bits use big-endian numbering: bit 0 is the most significant bit of the word, so bit n is `insn_i[31-n]`.

The block is purely combinational. It sits between the opcode table and operand fetch.

Top module: `opnd2_imm_gen`

## Requirements
- R1: Select code 1 (register) sets `reg_vld_o`, drives `reg_idx_o` with instruction bits 16..20, and leaves `imm_vld_o` and `spr_vld_o` low.
- R2: Select code 0 (none) leaves all three valids low and all data outputs zero.
- R3: Select code 12 (special register) sets only `spr_vld_o`. The id is `CTR_ID` (default 9) when extended-opcode value bit 9 (instruction bit 21, `insn_i[10]`) is 1, and `LR_ID` (default 8) otherwise.
- R4: Code 2 gives bits 16..31 zero-extended to 64 bits. Code 3 gives the same bits sign-extended from bit 15 of the field.
- R5: Code 4 gives bits 16..31 shifted left by 16, zero-extended. Code 5 gives bits 16..31 shifted left by 16, sign-extended from bit 31 of the result.
- R6: Code 6 gives bits 6..29 shifted left by 2. Codes 7 and 8 give bits 16..29 shifted left by 2. All three are zero-extended.
- R7: Code 9 gives an all-ones immediate.
- R8: Code 10 gives a 6-bit shift amount {bit 30, bits 16..20}, zero-extended. Code 11 gives bits 16..20, zero-extended.
- R9: Codes 13..15 leave all valids low and all data outputs zero.
- R10: At most one valid is high at any time. Every data output whose valid is low is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Raw instruction word |
| sel_i | input | 4 | Second-operand select code |
| reg_idx_o | output | 5 | Register read index |
| reg_vld_o | output | 1 | Register read request |
| imm_o | output | 64 | Immediate value |
| imm_vld_o | output | 1 | Immediate valid |
| spr_id_o | output | 10 | Special-register id |
| spr_vld_o | output | 1 | Special-register read request |

## Verification
Every output is a combinational function of the current instruction and select code. Results are therefore due in the same cycle the stimulus is applied, with no register in between. The bench changes inputs on the falling clock edge and samples all outputs a quarter period later, well before the next rising edge. It never compares against a value from an earlier cycle.

// File: rtl/opnd2_imm_gen.sv
module opnd2_imm_gen #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int SPR_W  = 10,
  parameter int CTR_ID = 9,
  parameter int LR_ID  = 8
) (
  input  logic [31:0]       insn_i,
  input  logic [3:0]        sel_i,
  output logic [RIDX_W-1:0] reg_idx_o,
  output logic              reg_vld_o,
  output logic [XLEN-1:0]   imm_o,
  output logic              imm_vld_o,
  output logic [SPR_W-1:0]  spr_id_o,
  output logic              spr_vld_o
);
  localparam logic [3:0] S_NONE = 4'd0,  S_REG  = 4'd1,  S_UI   = 4'd2,
                         S_SI   = 4'd3,  S_UIH  = 4'd4,  S_SIH  = 4'd5,
                         S_LI   = 4'd6,  S_BD   = 4'd7,  S_DS   = 4'd8,
                         S_M1   = 4'd9,  S_SH   = 4'd10, S_SH32 = 4'd11,
                         S_SPR  = 4'd12;

  wire [15:0] f_u16  = insn_i[15:0];
  wire [23:0] f_li   = insn_i[25:2];
  wire [13:0] f_bd   = insn_i[15:2];
  wire [4:0]  f_rb   = insn_i[15:11];
  wire        f_sh5  = insn_i[1];
  wire        f_xo9  = insn_i[10];

  always_comb begin
    reg_vld_o = 1'b0;
    reg_idx_o = '0;
    imm_vld_o = 1'b0;
    imm_o     = '0;
    spr_vld_o = 1'b0;
    spr_id_o  = '0;
    case (sel_i)
      S_REG: begin
        reg_vld_o = 1'b1;
        reg_idx_o = RIDX_W'(f_rb);
      end
      S_SPR: begin
        spr_vld_o = 1'b1;
        spr_id_o  = f_xo9 ? SPR_W'(CTR_ID) : SPR_W'(LR_ID);
      end
      S_UI:   begin imm_vld_o = 1'b1; imm_o = {{(XLEN-16){1'b0}}, f_u16}; end
      S_SI:   begin imm_vld_o = 1'b1; imm_o = {{(XLEN-16){f_u16[15]}}, f_u16}; end
      S_UIH:  begin imm_vld_o = 1'b1; imm_o = {{(XLEN-32){1'b0}}, f_u16, 16'h0}; end
      S_SIH:  begin imm_vld_o = 1'b1; imm_o = {{(XLEN-32){f_u16[15]}}, f_u16, 16'h0}; end
      S_LI:   begin imm_vld_o = 1'b1; imm_o = {{(XLEN-26){1'b0}}, f_li, 2'b00}; end
      S_BD, S_DS:
              begin imm_vld_o = 1'b1; imm_o = {{(XLEN-16){1'b0}}, f_bd, 2'b00}; end
      S_M1:   begin imm_vld_o = 1'b1; imm_o = '1; end
      S_SH:   begin imm_vld_o = 1'b1; imm_o = {{(XLEN-6){1'b0}}, f_sh5, f_rb}; end
      S_SH32: begin imm_vld_o = 1'b1; imm_o = {{(XLEN-5){1'b0}}, f_rb}; end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd2_imm_gen_chk.sv
module opnd2_imm_gen_chk #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int SPR_W  = 10,
  parameter int CTR_ID = 9,
  parameter int LR_ID  = 8
) (
  input logic [31:0]       insn_i,
  input logic [3:0]        sel_i,
  input logic [RIDX_W-1:0] reg_idx_o,
  input logic              reg_vld_o,
  input logic [XLEN-1:0]   imm_o,
  input logic              imm_vld_o,
  input logic [SPR_W-1:0]  spr_id_o,
  input logic              spr_vld_o
);
  always_comb begin
    if (!$isunknown({insn_i, sel_i})) begin
      a_r10_one_valid: assert ($countones({reg_vld_o, imm_vld_o, spr_vld_o}) <= 1);
      a_r10_imm_zero:  assert (imm_vld_o || imm_o == '0);
      a_r10_reg_zero:  assert (reg_vld_o || reg_idx_o == '0);
      a_r10_spr_zero:  assert (spr_vld_o || spr_id_o == '0);
      a_r1_reg_field:  assert (!reg_vld_o || reg_idx_o == RIDX_W'(insn_i[15:11]));
      a_r3_spr_id:     assert (!spr_vld_o ||
                               spr_id_o == (insn_i[10] ? SPR_W'(CTR_ID) : SPR_W'(LR_ID)));
      a_r9_undef_idle: assert (sel_i < 4'd13 || !(reg_vld_o || imm_vld_o || spr_vld_o));
      a_r2_none_idle:  assert (sel_i != 4'd0 || !(reg_vld_o || imm_vld_o || spr_vld_o));
    end
  end
endmodule

bind opnd2_imm_gen opnd2_imm_gen_chk #(
  .XLEN(XLEN), .RIDX_W(RIDX_W), .SPR_W(SPR_W), .CTR_ID(CTR_ID), .LR_ID(LR_ID)
) u_chk (
  .insn_i(insn_i), .sel_i(sel_i), .reg_idx_o(reg_idx_o), .reg_vld_o(reg_vld_o),
  .imm_o(imm_o), .imm_vld_o(imm_vld_o), .spr_id_o(spr_id_o), .spr_vld_o(spr_vld_o)
);

// File: tb/tb_opnd2_imm_gen.sv
module tb_opnd2_imm_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] insn;
  logic [3:0]  sel;
  logic [4:0]  reg_idx;
  logic        reg_vld;
  logic [63:0] imm;
  logic        imm_vld;
  logic [9:0]  spr_id;
  logic        spr_vld;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd2_imm_gen dut (
    .insn_i(insn), .sel_i(sel), .reg_idx_o(reg_idx), .reg_vld_o(reg_vld),
    .imm_o(imm), .imm_vld_o(imm_vld), .spr_id_o(spr_id), .spr_vld_o(spr_vld)
  );

  function automatic logic [63:0] bits(logic [31:0] w, int a, int b);
    logic [63:0] r = '0;
    for (int i = a; i <= b; i++) r = (r << 1) | 64'(w[31-i]);
    return r;
  endfunction

  function automatic string tag(logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R1";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      4'd10, 4'd11: return "R8";
      4'd12: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic apply_and_check(logic [31:0] w, logic [3:0] s);
    logic [4:0]  e_idx = '0;
    logic        e_rv = 0, e_iv = 0, e_sv = 0;
    logic [63:0] e_imm = '0;
    logic [63:0] u16;
    logic [9:0]  e_spr = '0;
    logic [82:0] got, exp;
    @(negedge clk);
    insn = w; sel = s;
    u16 = bits(w, 16, 31);
    case (s)
      4'd1:  begin e_rv = 1; e_idx = 5'(bits(w, 16, 20)); end
      4'd12: begin e_sv = 1; e_spr = (bits(w, 21, 21) != 0) ? 10'd9 : 10'd8; end
      4'd2:  begin e_iv = 1; e_imm = u16; end
      4'd3:  begin e_iv = 1; e_imm = u16[15] ? (u16 | 64'hFFFF_FFFF_FFFF_0000) : u16; end
      4'd4:  begin e_iv = 1; e_imm = u16 << 16; end
      4'd5:  begin e_iv = 1; e_imm = u16[15] ? ((u16 << 16) | 64'hFFFF_FFFF_0000_0000) : (u16 << 16); end
      4'd6:  begin e_iv = 1; e_imm = bits(w, 6, 29) << 2; end
      4'd7, 4'd8: begin e_iv = 1; e_imm = bits(w, 16, 29) << 2; end
      4'd9:  begin e_iv = 1; e_imm = {64{1'b1}}; end
      4'd10: begin e_iv = 1; e_imm = (bits(w, 30, 30) << 5) | bits(w, 16, 20); end
      4'd11: begin e_iv = 1; e_imm = bits(w, 16, 20); end
      default: ;
    endcase
    #(CLK_PERIOD/4);
    got = {reg_vld, reg_idx, imm_vld, imm, spr_vld, spr_id};
    exp = {e_rv, e_idx, e_iv, e_imm, e_sv, e_spr};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d insn=%h: actual rv=%b idx=%0d iv=%b imm=%h sv=%b spr=%0d expected rv=%b idx=%0d iv=%b imm=%h sv=%b spr=%0d",
               tag(s), s, w, reg_vld, reg_idx, imm_vld, imm, spr_vld, spr_id,
               e_rv, e_idx, e_iv, e_imm, e_sv, e_spr);
    end
    checks++;
    if ($countones({reg_vld, imm_vld, spr_vld}) > 1) begin
      errors++;
      $display("FAIL R10 sel=%0d: actual valids=%b expected at most one", s, {reg_vld, imm_vld, spr_vld});
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    insn = '0; sel = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    checks++;
    if ({reg_vld, imm_vld, spr_vld, imm, reg_idx, spr_id} !== '0) begin
      errors++;
      $display("FAIL R2 reset idle: actual imm=%h valids=%b expected all zero", imm, {reg_vld, imm_vld, spr_vld});
    end
    apply_and_check(32'h0000_8000, 4'd3);   // R4 negative SI
    apply_and_check(32'h0000_7FFF, 4'd3);   // R4 positive SI
    apply_and_check(32'h0000_FFFF, 4'd2);   // R4 UI no sign
    apply_and_check(32'h0000_8000, 4'd5);   // R5 SI_HI negative
    apply_and_check(32'h0000_8000, 4'd4);   // R5 UI_HI
    apply_and_check(32'h03FF_FFFC, 4'd6);   // R6 LI all ones
    apply_and_check(32'hFFFF_FFFF, 4'd7);   // R6 BD
    apply_and_check(32'hFFFF_FFFF, 4'd8);   // R6 DS
    apply_and_check(32'h0000_0000, 4'd9);   // R7
    apply_and_check(32'h0000_0002, 4'd10);  // R8 bit 30 only
    apply_and_check(32'h0000_F802, 4'd11);  // R8 SH32 ignores bit 30
    apply_and_check(32'h0000_0420, 4'd12);  // R3 CTR
    apply_and_check(32'hFFFF_FBFF, 4'd12);  // R3 LR
    apply_and_check(32'h0000_F800, 4'd1);   // R1
    apply_and_check(32'hFFFF_FFFF, 4'd0);   // R2
    for (int c = 13; c < 16; c++) apply_and_check(32'hFFFF_FFFF, 4'(c)); // R9
    for (int n = 0; n < 3000; n++) apply_and_check($urandom, 4'($urandom));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule